// File: doc/BRIEF.md
# Threshold-Based Fault Classification Manager

This block sits at the system level of an error-reporting network for a many-processor chip. Each error report names the processing unit that raised it. The block keeps a per-unit fault count and compares the updated count with a programmable threshold. From that comparison it decides whether the error was transient or permanent. A transient error produces a re-execute request for the job on that unit. A unit whose count passes the threshold is retired: it gets a sticky defective flag, which the scheduler reads as "do not schedule", and a mask bit that silences its error line in the aggregation network.

Reports are taken one at a time over a valid/ready handshake. Each accepted report is processed in a single busy cycle. Every accepted report also raises one log event that carries the unit, the verdict and the count. Repeated reports from the same unit drive its count up, and that is how a hard fault is recognised. Counters and flags are cleared only by reset.

Top module: `fcm_manager`

## Requirements
- R1: After synchronous reset, rpt_ready is 1, all defective and mask bits are 0, no event pulses are high, and the threshold equals THR_RESET (default 2).
- R2: A report is accepted on a rising edge where rpt_valid and rpt_ready are both 1. rpt_ready is 0 for the following cycle. In the cycle after that, rpt_ready is 1 again and the one-cycle result pulses are present.
- R3: Each accepted report for a unit that is in range and not defective raises that unit's count by one. The count saturates at 2^CNT_W-1, and log_count shows the updated value.
- R4: If the updated count is less than or equal to the threshold, retry_valid pulses, evt_unit names the unit, and log_kind is 0 (retry).
- R5: If the updated count is strictly greater than the threshold, retire_valid pulses instead of retry_valid, log_kind is 1 (retire), and the unit's defective and mask bits go to 1 in the same cycle as the pulse.
- R6: A report for a unit that is already defective is logged with log_kind 2. It leaves the count unchanged (log_count shows the stored count) and raises neither retry_valid nor retire_valid.
- R7: A report whose unit index is NUM_UNITS or more is logged with log_kind 3 and log_count 0. It changes no count or flag and raises no retry or retire pulse.
- R8: A threshold write (thr_wr) takes effect only while rpt_ready is 1. A write on the same edge as a report acceptance applies to that report. A write while the block is busy is ignored.
- R9: Defective flags, mask bits and counts never clear except by reset. Reset returns every count to 0.
- R10: Every accepted report gives exactly one log_valid pulse, and retry_valid and retire_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Error report present |
| rpt_ready | output | 1 | Block can accept a report |
| rpt_unit | input | IDX_W | Index of the reporting unit |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | CNT_W | New threshold value |
| retry_valid | output | 1 | One-cycle re-execute request |
| retire_valid | output | 1 | One-cycle retirement event |
| evt_unit | output | IDX_W | Unit named by the current event |
| defective | output | NUM_UNITS | Sticky do-not-schedule flags |
| net_mask | output | NUM_UNITS | Error-line mask bits for the aggregation network |
| log_valid | output | 1 | One-cycle log event |
| log_kind | output | 2 | 0 retry, 1 retire, 2 already defective, 3 bad index |
| log_count | output | CNT_W | Count reported with the log event |

## Verification
The bench targets the boundary where the updated count equals the threshold and the boundary where it first exceeds it. A design using the wrong comparison would retire a unit one report early or one report late. It sends further reports to a retired unit: a design that keeps counting or keeps requesting retries would show a changing log_count or a retry pulse. It also sends indices above the last unit, which a design without a range guard would let corrupt another unit's state. Threshold writes are tested while the block is busy and on the same edge as an accept, and a design with the wrong gating would change the verdict of the report in flight. A run with threshold 15 checks that the count saturates and never wraps to 0.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [1:0] {
    VERDICT_RETRY  = 2'd0,
    VERDICT_RETIRE = 2'd1,
    VERDICT_DEAD   = 2'd2,
    VERDICT_BADIDX = 2'd3
  } verdict_e;
endpackage

// File: rtl/fcm_history.sv
module fcm_history #(
  parameter int NUM_UNITS = 10,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM_UNITS];
  logic [CNT_W-1:0] rd_sel;

  // one saturating history counter per unit
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        cnt_q[g] <= wr_cnt;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (rd_idx == IDX_W'(i)) rd_sel = cnt_q[i];
  end

  // registered read port, captured at report acceptance
  always_ff @(posedge clk) begin
    if (rst)
      rd_cnt <= '0;
    else if (rd_en)
      rd_cnt <= rd_sel;
  end

  // R3: each write moves the count up by exactly one, or holds at the ceiling
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((CNT_W+1)'(wr_cnt) == (CNT_W+1)'(rd_cnt) + 1'b1) ||
              (rd_cnt == CNT_MAX && wr_cnt == CNT_MAX));
endmodule

// File: rtl/fcm_decide.sv
module fcm_decide
  import fcm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             dead,
  input  logic             bad,
  output verdict_e         verdict,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             cnt_we,
  output logic             retire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sat_inc;

  always_comb begin
    sat_inc = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
    verdict = VERDICT_RETRY;
    nxt_cnt = sat_inc;
    cnt_we  = 1'b0;
    retire  = 1'b0;
    if (bad) begin
      verdict = VERDICT_BADIDX;
      nxt_cnt = '0;
    end else if (dead) begin
      verdict = VERDICT_DEAD;
      nxt_cnt = cur_cnt;
    end else if (sat_inc > thr) begin
      verdict = VERDICT_RETIRE;
      cnt_we  = 1'b1;
      retire  = 1'b1;
    end else begin
      cnt_we  = 1'b1;
    end
  end
endmodule

// File: rtl/fcm_status.sv
module fcm_status #(
  parameter int NUM_UNITS = 10,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  output logic [NUM_UNITS-1:0] defective,
  output logic [NUM_UNITS-1:0] net_mask
);
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        defective[g] <= 1'b0;
        net_mask[g]  <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(g))) begin
        defective[g] <= 1'b1;
        net_mask[g]  <= 1'b1;
      end
    end
  end

  // R9: flags are sticky until reset
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (~defective & $past(defective)) == '0);
  p_mask_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (~net_mask & $past(net_mask)) == '0);
endmodule

// File: rtl/fcm_manager.sv
module fcm_manager
  import fcm_pkg::*;
#(
  parameter int NUM_UNITS = 10,
  parameter int CNT_W     = 4,
  parameter int THR_RESET = 2,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rpt_valid,
  output logic                 rpt_ready,
  input  logic [IDX_W-1:0]     rpt_unit,
  input  logic                 thr_wr,
  input  logic [CNT_W-1:0]     thr_data,
  output logic                 retry_valid,
  output logic                 retire_valid,
  output logic [IDX_W-1:0]     evt_unit,
  output logic [NUM_UNITS-1:0] defective,
  output logic [NUM_UNITS-1:0] net_mask,
  output logic                 log_valid,
  output logic [1:0]           log_kind,
  output logic [CNT_W-1:0]     log_count
);
  localparam logic [IDX_W-1:0] LAST_UNIT = IDX_W'(NUM_UNITS - 1);

  logic             busy_q;
  logic             accept;
  logic [IDX_W-1:0] idx_q;
  logic             bad_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cur_cnt;
  logic             dead_sel;
  verdict_e         verdict;
  logic [CNT_W-1:0] nxt_cnt;
  logic             cnt_we;
  logic             retire;

  assign rpt_ready = !busy_q;
  assign accept    = rpt_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      bad_q  <= 1'b0;
      thr_q  <= CNT_W'(THR_RESET);
    end else begin
      busy_q <= accept;
      if (accept) begin
        idx_q <= rpt_unit;
        bad_q <= (rpt_unit > LAST_UNIT);
      end
      if (thr_wr && !busy_q)
        thr_q <= thr_data;
    end
  end

  always_comb begin
    dead_sel = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (idx_q == IDX_W'(i)) dead_sel = defective[i];
  end

  fcm_history #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (accept),
    .rd_idx (rpt_unit),
    .rd_cnt (cur_cnt),
    .wr_en  (busy_q && cnt_we),
    .wr_idx (idx_q),
    .wr_cnt (nxt_cnt)
  );

  fcm_decide #(.CNT_W(CNT_W)) u_decide (
    .cur_cnt (cur_cnt),
    .thr     (thr_q),
    .dead    (dead_sel),
    .bad     (bad_q),
    .verdict (verdict),
    .nxt_cnt (nxt_cnt),
    .cnt_we  (cnt_we),
    .retire  (retire)
  );

  fcm_status #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .set_en    (busy_q && retire),
    .set_idx   (idx_q),
    .defective (defective),
    .net_mask  (net_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retry_valid  <= 1'b0;
      retire_valid <= 1'b0;
      log_valid    <= 1'b0;
      evt_unit     <= '0;
      log_kind     <= 2'd0;
      log_count    <= '0;
    end else begin
      retry_valid  <= busy_q && (verdict == VERDICT_RETRY);
      retire_valid <= busy_q && (verdict == VERDICT_RETIRE);
      log_valid    <= busy_q;
      if (busy_q) begin
        evt_unit  <= idx_q;
        log_kind  <= verdict;
        log_count <= nxt_cnt;
      end
    end
  end

  // R2: ready drops for the processing cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_ready) |=> !rpt_ready);
  // R10: one log pulse per accepted report
  p_log_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_ready) |=> ##1 log_valid);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(retry_valid && retire_valid));
  // R5: a retire pulse is seen together with the flag for that unit
  p_retire_marks_r5: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> ((defective >> evt_unit) & NUM_UNITS'(1)) != '0);
  // R7: bad index raises no action
  p_bad_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (log_valid && log_kind == 2'd3) |-> (!retry_valid && !retire_valid));
  // R8: threshold holds across a busy cycle
  p_thr_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !rpt_ready |=> $stable(thr_q));
endmodule

// File: tb/fcm_manager_bench.sv
`timescale 1ns/1ps
module fcm_manager_bench;
  localparam int N     = 10;
  localparam int CW    = 4;
  localparam int IW    = 4;
  localparam int NVEC  = 11;

  localparam int V_UNIT [NVEC] = '{3, 3, 3, 3, 0, 9, 12, 15, 0, 9, 9};
  localparam int V_KIND [NVEC] = '{0, 0, 1, 2, 0, 0, 3, 3, 0, 0, 1};
  localparam int V_CNT  [NVEC] = '{1, 2, 3, 3, 1, 1, 0, 0, 2, 2, 3};

  logic clk = 0;
  logic rst = 1;
  logic rpt_valid = 0;
  logic [IW-1:0] rpt_unit = '0;
  logic thr_wr = 0;
  logic [CW-1:0] thr_data = '0;
  logic rpt_ready, retry_valid, retire_valid, log_valid;
  logic [IW-1:0] evt_unit;
  logic [N-1:0] defective, net_mask;
  logic [1:0] log_kind;
  logic [CW-1:0] log_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fcm_manager #(.NUM_UNITS(N), .CNT_W(CW), .THR_RESET(2)) u_fcm_manager (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_unit(rpt_unit), .thr_wr(thr_wr), .thr_data(thr_data),
    .retry_valid(retry_valid), .retire_valid(retire_valid), .evt_unit(evt_unit),
    .defective(defective), .net_mask(net_mask), .log_valid(log_valid),
    .log_kind(log_kind), .log_count(log_count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // starts and ends at a falling edge
  task automatic send(input int unit, input bit wr_now, input int thr_now,
                      input bit wr_busy, input int thr_busy,
                      input int ek, input int ec);
    rpt_valid = 1;
    rpt_unit  = IW'(unit);
    thr_wr    = wr_now;
    thr_data  = CW'(thr_now);
    while (!rpt_ready) @(negedge clk);
    @(negedge clk);
    rpt_valid = 0;
    thr_wr    = wr_busy;
    thr_data  = CW'(thr_busy);
    chk(rpt_ready == 0, "R2 ready low while busy", rpt_ready, 0);
    @(negedge clk);
    thr_wr = 0;
    chk(rpt_ready == 1, "R2 ready back", rpt_ready, 1);
    chk(log_valid == 1, "R10 log pulse", log_valid, 1);
    chk(int'(log_kind) == ek, "R4/R5/R6/R7 log_kind", log_kind, ek);
    chk(int'(log_count) == ec, "R3 log_count", log_count, ec);
    chk(retry_valid == (ek == 0), "R4 retry_valid", retry_valid, ek == 0);
    chk(retire_valid == (ek == 1), "R5 retire_valid", retire_valid, ek == 1);
    chk(int'(evt_unit) == unit, "R4 evt_unit", evt_unit, unit);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(rpt_ready == 1, "R1 ready", rpt_ready, 1);
    chk(defective == '0, "R1 defective", defective, 0);
    chk(net_mask == '0, "R1 mask", net_mask, 0);
    chk(!log_valid && !retry_valid && !retire_valid, "R1 pulses", log_valid, 0);

    // table walk, threshold 2 from reset
    for (int i = 0; i < NVEC; i++)
      send(V_UNIT[i], 0, 0, 0, 0, V_KIND[i], V_CNT[i]);
    chk(defective == N'((1 << 3) | (1 << 9)), "R5 defective set", defective, (1<<3)|(1<<9));
    chk(net_mask == N'((1 << 3) | (1 << 9)), "R5 mask set", net_mask, (1<<3)|(1<<9));
    @(negedge clk);
    chk(log_valid == 0, "R10 single pulse", log_valid, 0);
    // R6 retired unit stays put, R9 flags persist
    send(9, 0, 0, 0, 0, 2, 3);
    chk(defective == N'((1 << 3) | (1 << 9)), "R9 flags persist", defective, (1<<3)|(1<<9));

    // R9 reset clears counts and flags
    do_reset();
    chk(defective == '0, "R9 reset clears flags", defective, 0);
    send(3, 0, 0, 0, 0, 0, 1);

    // R8 busy write ignored
    do_reset();
    send(1, 0, 0, 1, 0, 0, 1);
    send(1, 0, 0, 0, 0, 0, 2);
    // R8 same-edge write applies to the report
    send(2, 1, 0, 0, 0, 1, 1);
    chk(defective == N'(1 << 2), "R8 same-edge threshold", defective, 1 << 2);

    // R3 saturation with threshold 15
    do_reset();
    @(negedge clk);
    thr_wr = 1;
    thr_data = 4'd15;
    @(negedge clk);
    thr_wr = 0;
    for (int k = 1; k <= 17; k++)
      send(5, 0, 0, 0, 0, 0, (k > 15) ? 15 : k);
    chk(defective == '0, "R3 saturated never retires", defective, 0);

    finish_run();
  end
endmodule